// File: doc/BRIEF.md
# 32-bit Bit-Manipulation Execute Unit

This unit sits in the execute stage of a 32-bit integer core, next to the ordinary ALU. Each cycle it receives the raw 32-bit instruction word and the values of the two source registers. It decodes the register-register (OP, `0110011`) and register-immediate (OP-IMM, `0010011`) major opcodes and finds the basic bit-manipulation operations within them. These are: logic with an inverted second operand, signed and unsigned minimum and maximum, rotates by register and by immediate, leading-zero count, trailing-zero count, population count, sign extension of a byte or halfword, zero extension of a halfword, the byte-wise OR-combine and the byte reversal.

The unit is purely combinational. Its result appears in the same cycle as its inputs. The decoder is an enumerated classification with one named outcome per operation (`OP_ANDN` … `OP_REV8`) plus `OP_NONE`. Each word falls into exactly one of three classes:
- **Matched.** The word is a supported operation. `valid` is set and the result is driven.
- **Illegal.** The word falls inside one of the bit-manipulation encoding groups but matches no supported pattern. `illegal` is set and the result is forced to zero.
- **Base.** The word is any other instruction, including base-ISA and multiply words. Both flags stay low and the result is zero, so the core's normal ALU handles it.

Top module: `bmu_exec`

## Requirements
- R1: `valid_o` is set only for an OP or OP-IMM opcode whose fields match a supported operation. `valid_o` and `illegal_o` are never both set. Any other opcode leaves both flags low.
- R2: OP with funct7 `0100000` gives the following results:
  - funct3=7: rs1 AND NOT rs2.
  - funct3=6: rs1 OR NOT rs2.
  - funct3=4: NOT(rs1 XOR rs2).
- R3: OP with funct7 `0000101` gives the following results:
  - funct3=4: signed minimum.
  - funct3=5: unsigned minimum.
  - funct3=6: signed maximum.
  - funct3=7: unsigned maximum.
- R4: OP with funct7 `0110000` rotates rs1 by rs2[4:0]. funct3=1 rotates left and funct3=5 rotates right. The upper bits of rs2 are ignored.
- R5: OP-IMM with funct3=5 and instruction bits [31:25]=`0110000` rotates rs1 right by instruction bits [24:20].
- R6: OP-IMM with funct3=1 selects a count by its 12-bit immediate. Immediate 0x600 counts leading zeros and 0x601 counts trailing zeros. Both counts return 32 for a zero operand.
- R7: OP-IMM with funct3=1 and immediate 0x602 returns the number of set bits in rs1 (0 to 32).
- R8: OP-IMM with funct3=1 sign-extends part of rs1. Immediate 0x604 sign-extends bits [7:0] and immediate 0x605 sign-extends bits [15:0].
- R9: OP with funct7 `0000100`, funct3=4 and instruction bits [24:20]=0 returns rs1 AND 0xFFFF. With a nonzero value in bits [24:20] the same word is illegal.
- R10: OP-IMM with funct3=5 and immediate 0x287 sets each result byte as follows: 0xFF if the matching byte of rs1 is nonzero, 0x00 if it is zero.
- R11: OP-IMM with funct3=5 and immediate 0x698 reverses the byte order of rs1, so rs1 byte 0 becomes result byte 3.
- R12: `illegal_o` is set for the following words:
  - OP with funct7 `0100000` and funct3 of 1, 2 or 3.
  - OP with funct7 `0000101` and funct3 below 4.
  - OP with funct7 `0110000` and funct3 other than 1 or 5.
  - OP with funct7 `0000100` other than a legal R9 word.
  - OP-IMM funct3=1 with an immediate whose bits [11:5] are neither 0 nor `0110000`.
  - OP-IMM funct3=1 with bits [11:5]=`0110000` and a low field outside {0,1,2,4,5}.
  - OP-IMM funct3=5 with bits [31:25] not in {`0000000`, `0100000`, `0110000`} and an immediate other than 0x287 or 0x698.
- R13: Whenever `valid_o` is low, `result_o` is zero. This covers both illegal words and base-ISA words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Raw instruction word |
| rs1_i | input | 32 | First source operand value |
| rs2_i | input | 32 | Second source operand value |
| result_o | output | 32 | Operation result, zero unless valid |
| valid_o | output | 1 | Word matched a supported operation |
| illegal_o | output | 1 | Word is in a bit-manipulation group but matches no pattern |

## Verification
The unit holds no state, so a wrong classification or operand path shows at the ports in the same cycle the word is presented. A flipped decode branch shows either as a flag pair that disagrees with the requirement or as a nonzero result beside a low valid flag. A miscounted loop bound shows on the corner operands 0, 0xFFFFFFFF, 0x80000000 and 0x7FFFFFFF, where counts of 0 and 32 and sign boundaries are reached. Every case is sampled one half-cycle after it is driven, so a fault is reported against the very word that exposed it.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;

    localparam logic [6:0] F7_BASE    = 7'b0000000;
    localparam logic [6:0] F7_NEGATE  = 7'b0100000;
    localparam logic [6:0] F7_MINMAX  = 7'b0000101;
    localparam logic [6:0] F7_ROTATE  = 7'b0110000;
    localparam logic [6:0] F7_ZEXT    = 7'b0000100;

    localparam logic [11:0] IMM_ORCB  = 12'h287;
    localparam logic [11:0] IMM_REV8  = 12'h698;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_ANDN,
        OP_ORN,
        OP_XNOR,
        OP_MIN,
        OP_MINU,
        OP_MAX,
        OP_MAXU,
        OP_ROL,
        OP_ROR,
        OP_RORI,
        OP_CLZ,
        OP_CTZ,
        OP_CPOP,
        OP_SEXTB,
        OP_SEXTH,
        OP_ZEXTH,
        OP_ORCB,
        OP_REV8
    } bmu_op_e;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [6:0]  opc_i,
    input  logic [2:0]  f3_i,
    input  logic [11:0] imm_i,
    output bmu_op_e     op_o,
    output logic        bad_o
);

    logic [6:0] hi7;
    logic [4:0] lo5;

    assign hi7 = imm_i[11:5];
    assign lo5 = imm_i[4:0];

    always_comb begin
        op_o  = OP_NONE;
        bad_o = 1'b0;
        unique case (opc_i)
            OPC_REG: begin
                unique case (hi7)
                    F7_NEGATE: begin
                        case (f3_i)
                            3'd7:       op_o = OP_ANDN;
                            3'd6:       op_o = OP_ORN;
                            3'd4:       op_o = OP_XNOR;
                            3'd0, 3'd5: ;
                            default:    bad_o = 1'b1;
                        endcase
                    end
                    F7_MINMAX: begin
                        case (f3_i)
                            3'd4:    op_o = OP_MIN;
                            3'd5:    op_o = OP_MINU;
                            3'd6:    op_o = OP_MAX;
                            3'd7:    op_o = OP_MAXU;
                            default: bad_o = 1'b1;
                        endcase
                    end
                    F7_ROTATE: begin
                        case (f3_i)
                            3'd1:    op_o = OP_ROL;
                            3'd5:    op_o = OP_ROR;
                            default: bad_o = 1'b1;
                        endcase
                    end
                    F7_ZEXT: begin
                        if (f3_i == 3'd4 && lo5 == 5'd0) op_o  = OP_ZEXTH;
                        else                             bad_o = 1'b1;
                    end
                    default: ;
                endcase
            end
            OPC_IMM: begin
                unique case (f3_i)
                    3'd1: begin
                        if (hi7 == F7_BASE) begin
                        end else if (hi7 == F7_ROTATE) begin
                            case (lo5)
                                5'd0:    op_o = OP_CLZ;
                                5'd1:    op_o = OP_CTZ;
                                5'd2:    op_o = OP_CPOP;
                                5'd4:    op_o = OP_SEXTB;
                                5'd5:    op_o = OP_SEXTH;
                                default: bad_o = 1'b1;
                            endcase
                        end else begin
                            bad_o = 1'b1;
                        end
                    end
                    3'd5: begin
                        if (hi7 == F7_BASE || hi7 == F7_NEGATE) begin
                        end else if (hi7 == F7_ROTATE) begin
                            op_o = OP_RORI;
                        end else if (imm_i == IMM_ORCB) begin
                            op_o = OP_ORCB;
                        end else if (imm_i == IMM_REV8) begin
                            op_o = OP_REV8;
                        end else begin
                            bad_o = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
    parameter int W = 32
) (
    input  logic [W-1:0]          src_i,
    output logic [$clog2(W):0]    lead_o,
    output logic [$clog2(W):0]    trail_o,
    output logic [$clog2(W):0]    ones_o
);

    localparam int CW = $clog2(W) + 1;

    always_comb begin
        lead_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (src_i[i]) lead_o = CW'(W - 1 - i);
        end
    end

    always_comb begin
        trail_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (src_i[i]) trail_o = CW'(i);
        end
    end

    always_comb begin
        ones_o = '0;
        for (int i = 0; i < W; i++) begin
            ones_o = ones_o + CW'(src_i[i]);
        end
    end

endmodule

// File: rtl/bmu_bytes.sv
module bmu_bytes #(
    parameter int W = 32
) (
    input  logic [W-1:0] src_i,
    output logic [W-1:0] orc_o,
    output logic [W-1:0] rev_o,
    output logic [W-1:0] sextb_o,
    output logic [W-1:0] sexth_o,
    output logic [W-1:0] zexth_o
);

    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign orc_o[b*8 +: 8] = (|src_i[b*8 +: 8]) ? 8'hFF : 8'h00;
        assign rev_o[b*8 +: 8] = src_i[(NB-1-b)*8 +: 8];
    end

    assign sextb_o = {{(W-8){src_i[7]}}, src_i[7:0]};
    assign sexth_o = {{(W-16){src_i[15]}}, src_i[15:0]};
    assign zexth_o = {{(W-16){1'b0}}, src_i[15:0]};

endmodule

// File: rtl/bmu_exec.sv
module bmu_exec
    import bmu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [31:0]  insn_i,
    input  logic [W-1:0] rs1_i,
    input  logic [W-1:0] rs2_i,
    output logic [W-1:0] result_o,
    output logic         valid_o,
    output logic         illegal_o
);

    localparam int SW = $clog2(W);
    localparam int CW = SW + 1;

    bmu_op_e       op;
    logic          bad;
    logic [SW-1:0] amt;
    logic [2*W-1:0] dbl_l, dbl_r;
    logic [CW-1:0] n_lead, n_trail, n_ones;
    logic [W-1:0]  v_orc, v_rev, v_sextb, v_sexth, v_zexth;
    logic          s_lt, u_lt;
    logic          unused_fields;

    assign unused_fields = ^{insn_i[19:15], insn_i[11:7]};

    bmu_decode u_decode (
        .opc_i (insn_i[6:0]),
        .f3_i  (insn_i[14:12]),
        .imm_i (insn_i[31:20]),
        .op_o  (op),
        .bad_o (bad)
    );

    bmu_count #(.W(W)) u_count (
        .src_i   (rs1_i),
        .lead_o  (n_lead),
        .trail_o (n_trail),
        .ones_o  (n_ones)
    );

    bmu_bytes #(.W(W)) u_bytes (
        .src_i   (rs1_i),
        .orc_o   (v_orc),
        .rev_o   (v_rev),
        .sextb_o (v_sextb),
        .sexth_o (v_sexth),
        .zexth_o (v_zexth)
    );

    assign amt   = (op == OP_RORI) ? insn_i[20 +: SW] : rs2_i[SW-1:0];
    assign dbl_l = {rs1_i, rs1_i} << amt;
    assign dbl_r = {rs1_i, rs1_i} >> amt;
    assign s_lt  = $signed(rs1_i) < $signed(rs2_i);
    assign u_lt  = rs1_i < rs2_i;

    always_comb begin
        unique case (op)
            OP_ANDN:  result_o = rs1_i & ~rs2_i;
            OP_ORN:   result_o = rs1_i | ~rs2_i;
            OP_XNOR:  result_o = ~(rs1_i ^ rs2_i);
            OP_MIN:   result_o = s_lt ? rs1_i : rs2_i;
            OP_MINU:  result_o = u_lt ? rs1_i : rs2_i;
            OP_MAX:   result_o = s_lt ? rs2_i : rs1_i;
            OP_MAXU:  result_o = u_lt ? rs2_i : rs1_i;
            OP_ROL:   result_o = dbl_l[2*W-1:W];
            OP_ROR,
            OP_RORI:  result_o = dbl_r[W-1:0];
            OP_CLZ:   result_o = W'(n_lead);
            OP_CTZ:   result_o = W'(n_trail);
            OP_CPOP:  result_o = W'(n_ones);
            OP_SEXTB: result_o = v_sextb;
            OP_SEXTH: result_o = v_sexth;
            OP_ZEXTH: result_o = v_zexth;
            OP_ORCB:  result_o = v_orc;
            OP_REV8:  result_o = v_rev;
            default:  result_o = '0;
        endcase
    end

    assign valid_o   = (op != OP_NONE);
    assign illegal_o = bad;

endmodule

// File: rtl/bmu_exec_chk.sv
module bmu_exec_chk #(
    parameter int W = 32
) (
    input logic [31:0]  insn_i,
    input logic [W-1:0] rs1_i,
    input logic [W-1:0] rs2_i,
    input logic [W-1:0] result_o,
    input logic         valid_o,
    input logic         illegal_o
);

    logic known;
    logic is_clz, is_rev8, is_zext_grp, is_opc;

    assign known       = !$isunknown({insn_i, rs1_i, rs2_i});
    assign is_opc      = insn_i[6:0] == 7'b0110011 || insn_i[6:0] == 7'b0010011;
    assign is_clz      = insn_i[6:0] == 7'b0010011 && insn_i[14:12] == 3'd1 &&
                         insn_i[31:20] == 12'h600;
    assign is_rev8     = insn_i[6:0] == 7'b0010011 && insn_i[14:12] == 3'd5 &&
                         insn_i[31:20] == 12'h698;
    assign is_zext_grp = insn_i[6:0] == 7'b0110011 && insn_i[31:25] == 7'b0000100;

    always_comb begin
        if (known) begin
            a_r1_flags_exclusive: assert (!(valid_o && illegal_o))
                else $error("valid and illegal both set");
            a_r1_opcode_gate: assert (!(valid_o || illegal_o) || is_opc)
                else $error("flag raised outside OP/OP-IMM");
            a_r13_zero_when_not_valid: assert (valid_o || result_o == '0)
                else $error("nonzero result without valid");
            a_r6_clz_of_zero: assert (!(is_clz && rs1_i == '0) || (valid_o && result_o == W'(W)))
                else $error("leading-zero count of zero is not W");
            a_r11_rev8_ends: assert (!is_rev8 ||
                    (result_o[W-1 -: 8] == rs1_i[7:0] && result_o[7:0] == rs1_i[W-1 -: 8]))
                else $error("byte reverse end bytes wrong");
            a_r9_zext_rs2_nonzero: assert (!(is_zext_grp && insn_i[24:20] != 5'd0) || illegal_o)
                else $error("zext with nonzero rs2 not illegal");
        end
    end

endmodule

bind bmu_exec bmu_exec_chk #(.W(W)) chk_i (.*);

// File: tb/bmu_exec_tb.sv
module bmu_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn, a, b;
    logic [31:0] res;
    logic        vld, ill;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    bmu_exec dut_i (
        .insn_i    (insn),
        .rs1_i     (a),
        .rs2_i     (b),
        .result_o  (res),
        .valid_o   (vld),
        .illegal_o (ill)
    );

    localparam logic [6:0] OR_ = 7'b0110011;
    localparam logic [6:0] OI_ = 7'b0010011;

    logic [31:0] corner [4] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] r2,
                                          input logic [2:0] f3);
        return {f7, r2, 5'd3, f3, 5'd9, OR_};
    endfunction

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3);
        return {imm, 5'd4, f3, 5'd10, OI_};
    endfunction

    function automatic int m_clz(input logic [31:0] x);
        int n = 0;
        while (n < 32 && !x[31-n]) n++;
        return n;
    endfunction

    function automatic int m_ctz(input logic [31:0] x);
        int n = 0;
        while (n < 32 && !x[n]) n++;
        return n;
    endfunction

    function automatic int m_pop(input logic [31:0] x);
        int n = 0;
        for (int i = 0; i < 32; i++) if (x[i]) n++;
        return n;
    endfunction

    function automatic logic [31:0] m_rol(input logic [31:0] x, input int n);
        logic [31:0] y = x;
        for (int i = 0; i < (n % 32); i++) y = {y[30:0], y[31]};
        return y;
    endfunction

    function automatic logic [31:0] m_ror(input logic [31:0] x, input int n);
        logic [31:0] y = x;
        for (int i = 0; i < (n % 32); i++) y = {y[0], y[31:1]};
        return y;
    endfunction

    function automatic logic [31:0] m_orc(input logic [31:0] x);
        logic [31:0] y;
        for (int k = 0; k < 4; k++) y[8*k +: 8] = (x[8*k +: 8] != 0) ? 8'hFF : 8'h00;
        return y;
    endfunction

    task automatic run(input string tag, input logic [31:0] w, input logic [31:0] x,
                       input logic [31:0] y, input logic ev, input logic ei,
                       input logic [31:0] er);
        @(posedge clk);
        insn = w; a = x; b = y;
        @(negedge clk);
        checks++;
        if (vld !== ev || ill !== ei || res !== er) begin
            errors++;
            $display("FAIL %s insn=%h a=%h b=%h: got v=%b i=%b r=%h, expected v=%b i=%b r=%h",
                     tag, w, x, y, vld, ill, res, ev, ei, er);
        end
    endtask

    task automatic t_reset_state();
        run("R13", 32'h0000_0013, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 32'h0);
        run("R1", 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_logic();
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                run("R2", enc_r(7'b0100000, 5'd5, 3'd7), corner[i], corner[j], 1, 0, corner[i] & ~corner[j]);
                run("R2", enc_r(7'b0100000, 5'd5, 3'd6), corner[i], corner[j], 1, 0, corner[i] | ~corner[j]);
                run("R2", enc_r(7'b0100000, 5'd5, 3'd4), corner[i], corner[j], 1, 0, ~(corner[i] ^ corner[j]));
            end
        for (int k = 0; k < 6; k++) begin
            logic [31:0] x = $urandom, y = $urandom;
            run("R2", enc_r(7'b0100000, 5'd5, 3'd7), x, y, 1, 0, x & ~y);
        end
    endtask

    task automatic t_minmax();
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                logic [31:0] x = corner[i], y = corner[j];
                run("R3", enc_r(7'b0000101, 5'd5, 3'd4), x, y, 1, 0, ($signed(x) < $signed(y)) ? x : y);
                run("R3", enc_r(7'b0000101, 5'd5, 3'd5), x, y, 1, 0, (x < y) ? x : y);
                run("R3", enc_r(7'b0000101, 5'd5, 3'd6), x, y, 1, 0, ($signed(x) > $signed(y)) ? x : y);
                run("R3", enc_r(7'b0000101, 5'd5, 3'd7), x, y, 1, 0, (x > y) ? x : y);
            end
    endtask

    task automatic t_rotate();
        for (int k = 0; k < 10; k++) begin
            logic [31:0] x = (k < 4) ? corner[k] : $urandom;
            logic [31:0] y = {$urandom} | 32'hFFFF_FF00 & 32'h0000_FFE0;
            y[4:0] = 5'(k * 7);
            run("R4", enc_r(7'b0110000, 5'd5, 3'd1), x, y, 1, 0, m_rol(x, int'(y[4:0])));
            run("R4", enc_r(7'b0110000, 5'd5, 3'd5), x, y, 1, 0, m_ror(x, int'(y[4:0])));
            run("R5", enc_i({7'b0110000, 5'(k * 3)}, 3'd5), x, 32'hFFFF_FFFF, 1, 0, m_ror(x, k * 3));
        end
    endtask

    task automatic t_counts();
        for (int k = 0; k < 10; k++) begin
            logic [31:0] x = (k < 4) ? corner[k] : ($urandom >> k);
            run("R6", enc_i(12'h600, 3'd1), x, 32'h0, 1, 0, 32'(m_clz(x)));
            run("R6", enc_i(12'h601, 3'd1), x, 32'h0, 1, 0, 32'(m_ctz(x)));
            run("R7", enc_i(12'h602, 3'd1), x, 32'h0, 1, 0, 32'(m_pop(x)));
        end
    endtask

    task automatic t_extend();
        logic [31:0] vals [4] = '{32'h1234_5680, 32'h0000_7F7F, 32'hFFFF_8001, 32'h89AB_CD12};
        for (int k = 0; k < 4; k++) begin
            logic [31:0] x = vals[k];
            run("R8", enc_i(12'h604, 3'd1), x, 32'h0, 1, 0, {{24{x[7]}}, x[7:0]});
            run("R8", enc_i(12'h605, 3'd1), x, 32'h0, 1, 0, {{16{x[15]}}, x[15:0]});
            run("R9", enc_r(7'b0000100, 5'd0, 3'd4), x, 32'hFFFF_FFFF, 1, 0, x & 32'h0000_FFFF);
        end
        run("R9", enc_r(7'b0000100, 5'd1, 3'd4), 32'hABCD_1234, 32'h0, 0, 1, 32'h0);
    endtask

    task automatic t_bytes();
        logic [31:0] vals [5] = '{32'h0, 32'h0100_0080, 32'h0011_0000, 32'hFFFF_FFFF, 32'h1122_3344};
        for (int k = 0; k < 5; k++) begin
            logic [31:0] x = vals[k];
            run("R10", enc_i(12'h287, 3'd5), x, 32'h0, 1, 0, m_orc(x));
            run("R11", enc_i(12'h698, 3'd5), x, 32'h0, 1, 0, {x[7:0], x[15:8], x[23:16], x[31:24]});
        end
    endtask

    task automatic t_illegal();
        logic [31:0] x = 32'hDEAD_BEEF;
        run("R12", enc_r(7'b0100000, 5'd5, 3'd1), x, x, 0, 1, 32'h0);
        run("R12", enc_r(7'b0100000, 5'd5, 3'd3), x, x, 0, 1, 32'h0);
        run("R12", enc_r(7'b0000101, 5'd5, 3'd1), x, x, 0, 1, 32'h0);
        run("R12", enc_r(7'b0110000, 5'd5, 3'd0), x, x, 0, 1, 32'h0);
        run("R12", enc_r(7'b0000100, 5'd0, 3'd0), x, x, 0, 1, 32'h0);
        run("R12", enc_i(12'h603, 3'd1), x, x, 0, 1, 32'h0);
        run("R12", enc_i(12'h606, 3'd1), x, x, 0, 1, 32'h0);
        run("R12", enc_i(12'h280, 3'd1), x, x, 0, 1, 32'h0);
        run("R12", enc_i(12'h286, 3'd5), x, x, 0, 1, 32'h0);
        run("R12", enc_i(12'h699, 3'd5), x, x, 0, 1, 32'h0);
    endtask

    task automatic t_base();
        logic [31:0] x = 32'h0F0F_00F0;
        run("R1", enc_r(7'b0000000, 5'd5, 3'd7), x, x, 0, 0, 32'h0);
        run("R1", enc_r(7'b0100000, 5'd5, 3'd0), x, x, 0, 0, 32'h0);
        run("R1", enc_r(7'b0000001, 5'd5, 3'd4), x, x, 0, 0, 32'h0);
        run("R13", enc_i(12'h005, 3'd1), x, x, 0, 0, 32'h0);
        run("R13", enc_i(12'h405, 3'd5), x, x, 0, 0, 32'h0);
        run("R1", {12'h600, 5'd4, 3'd1, 5'd10, 7'b0110111}, x, x, 0, 0, 32'h0);
    endtask

    initial begin
        insn = 32'h0; a = 32'h0; b = 32'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_logic();
        t_minmax();
        t_rotate();
        t_counts();
        t_extend();
        t_bytes();
        t_illegal();
        t_base();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule